// File: doc/BRIEF.md
# Multi-Lane Marker-Based Deskew Unit

This block sits after the 8b/10b decoders of up to eight received byte lanes and removes the skew between them. Every lane delivers a data byte, a control flag and a valid strobe each clock. Each lane runs through a short delay line. For each alignment group, a tracker watches the incoming bytes for the alignment control character. When every lane of the group has shown it inside a bounded window, the tracker delays the early lanes so that all those characters leave the block in the same output cycle, as one column.

A two-bit mode input sets the grouping at run time. The groups can be single independent lanes, pairs, quads, or all eight lanes together. Once a group is locked, its tracker watches each later column of alignment characters at the delay-line taps. A column that is only partly present signals a loss of alignment and starts a new search. Per lane, the outputs are the deskewed byte, control flag and valid strobe, the lock state of the lane's group, and a one-cycle loss pulse.

Top module: `mlane_deskew`

## Requirements
- R1: The alignment character is data byte 0x7C with both the control flag and the valid strobe high. The same byte with the control flag low, or with valid low, is never taken as a marker.
- R2: The mode code `grp_mode` sets the groups as follows. 2'b00 makes each lane its own unaligned lane. 2'b10 forms pairs {0,1},{2,3},{4,5},{6,7}. 2'b01 forms quads {0..3},{4..7}. 2'b11 forms one group of all eight lanes.
- R3: A group locks when the last member lane's marker arrives no more than WIN (default 8) cycles after the first member lane's marker. From then on, lane j of the group is delayed by an extra tap of (latest arrival offset − lane j's arrival offset) cycles, so the markers leave as one column.
- R4: If the markers of a group's lanes are spread over more than WIN cycles, the group never locks, and its lanes stay at base latency.
- R5: Groups are independent. The lock, loss and delay of one group never change another group's outputs.
- R6: While locked, a tap column in which some but not all member lanes carry a marker raises `lane_lost` for exactly one cycle on every member lane. In the same cycle it clears `lane_locked`, returns the taps to zero, and restarts the search, which can lock again.
- R7: With zero tap (mode 2'b00, or a group that is not locked), a lane's byte, control flag and valid strobe that are sampled at one rising edge appear on the outputs after the next rising edge. In mode 2'b00, `lane_locked` stays low.
- R8: A change of `grp_mode` clears every lock and restarts every search at the edge where the new code is first sampled.
- R9: Synchronous active-high `rst` clears all delay-line contents, the outputs, the lock flags and the loss pulses.
- R10: No lane's tap ever exceeds WIN, which is smaller than the delay-line depth DEPTH (default 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all lanes |
| rst | input | 1 | Synchronous active-high reset |
| grp_mode | input | 2 | Grouping code (see R2) |
| rx_data | input | LANES*DATA_W | Decoded bytes, lane j at bits j*DATA_W upward |
| rx_ctrl | input | LANES | Control-character flag per lane |
| rx_valid | input | LANES | Byte valid strobe per lane |
| dsk_data | output | LANES*DATA_W | Deskewed bytes |
| dsk_ctrl | output | LANES | Deskewed control flags |
| dsk_valid | output | LANES | Deskewed valid strobes |
| lane_locked | output | LANES | Lock state of the lane's group |
| lane_lost | output | LANES | One-cycle pulse when the lane's group loses alignment |

## Verification
The column and tap-bound properties assume three things about the inputs. All lanes share one clock rate. The skew inside a group spans at most WIN cycles. Markers on a lane are spaced more than twice WIN apart, so a search can never pair a marker with a neighbour of the next column. The stimulus builds every lane from a single pattern with a marker every 20 cycles, shifted by a per-lane skew of at most 9 cycles. Only one deliberate out-of-window pair exceeds the span, and it is checked for staying unlocked. The decoy bytes (0x7C without the control flag, and 0x7C with valid low) appear only away from the marker phases, so they are never near a real column.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

   typedef enum logic [1:0] {
      GRP_NONE = 2'b00,
      GRP_QUAD = 2'b01,
      GRP_TWIN = 2'b10,
      GRP_ALL  = 2'b11
   } grp_mode_e;

   // Lane-index bits that vary inside one group for the given grouping.
   function automatic logic [2:0] grp_low_bits(grp_mode_e m);
      case (m)
         GRP_TWIN: return 3'd1;
         GRP_QUAD: return 3'd3;
         GRP_ALL:  return 3'd7;
         default:  return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/lane_delay_line.sv
module lane_delay_line #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned DEPTH     = 16,
   parameter logic [DATA_W-1:0] MARK_CHAR = 8'h7C,
   localparam int unsigned TAP_W    = $clog2(DEPTH),
   localparam int unsigned ENT_W    = DATA_W + 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              in_ctrl,
   input  logic [DATA_W-1:0] in_data,
   input  logic [TAP_W-1:0]  tap,
   output logic              tap_mark,
   output logic              out_valid,
   output logic              out_ctrl,
   output logic [DATA_W-1:0] out_data
);

   logic [ENT_W-1:0] line_q [DEPTH];
   logic [ENT_W-1:0] tap_ent;
   logic [ENT_W-1:0] out_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
      end else begin
         line_q[0] <= {in_valid, in_ctrl, in_data};
         for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
      end
   end

   assign tap_ent  = line_q[tap];
   assign tap_mark = tap_ent[ENT_W-1] && tap_ent[ENT_W-2] &&
                     (tap_ent[DATA_W-1:0] == MARK_CHAR);

   always_ff @(posedge clk) begin
      if (rst) out_q <= '0;
      else     out_q <= tap_ent;
   end

   assign out_valid = out_q[ENT_W-1];
   assign out_ctrl  = out_q[ENT_W-2];
   assign out_data  = out_q[DATA_W-1:0];

endmodule

// File: rtl/group_tracker.sv
module group_tracker #(
   parameter int unsigned LANES = 8,
   parameter int unsigned WIN   = 8,
   parameter int unsigned TAP_W = 4,
   localparam int unsigned OFF_W = $clog2(WIN + 1)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        clear,
   input  logic [LANES-1:0]            member,
   input  logic [LANES-1:0]            in_mark,
   input  logic [LANES-1:0]            tap_mark,
   output logic [LANES-1:0][TAP_W-1:0] tap_sel,
   output logic                        locked,
   output logic                        lost
);

   typedef enum logic {ST_HUNT, ST_LOCK} trk_state_e;

   trk_state_e                  st_q;
   logic                        armed_q;
   logic [OFF_W-1:0]            cnt_q;
   logic [LANES-1:0]            seen_q;
   logic [LANES-1:0][OFF_W-1:0] off_q;
   logic [LANES-1:0][TAP_W-1:0] dly_q;
   logic                        lost_q;

   logic [LANES-1:0]            hits, fresh, seen_nx, col;
   logic [OFF_W-1:0]            cnt_nx;
   logic [LANES-1:0][OFF_W-1:0] off_nx;
   logic [LANES-1:0][TAP_W-1:0] dly_nx;
   logic                        started, done, expire, partial;

   always_comb begin
      hits    = in_mark & member;
      col     = tap_mark & member;
      cnt_nx  = armed_q ? cnt_q + 1'b1 : '0;
      fresh   = armed_q ? (hits & ~seen_q) : hits;
      seen_nx = (armed_q ? seen_q : '0) | fresh;
      for (int j = 0; j < LANES; j++) begin
         off_nx[j] = fresh[j] ? cnt_nx : (armed_q ? off_q[j] : '0);
         dly_nx[j] = member[j] ? TAP_W'(cnt_nx - off_nx[j]) : '0;
      end
      started = armed_q || (hits != '0);
      done    = started && (member != '0) && (seen_nx == member);
      expire  = armed_q && !done && (cnt_nx == OFF_W'(WIN));
      partial = (col != '0) && (col != member);
   end

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         st_q    <= ST_HUNT;
         armed_q <= 1'b0;
         cnt_q   <= '0;
         seen_q  <= '0;
         off_q   <= '0;
         dly_q   <= '0;
         lost_q  <= 1'b0;
      end else begin
         lost_q <= 1'b0;
         case (st_q)
            ST_HUNT: begin
               if (done) begin
                  st_q    <= ST_LOCK;
                  dly_q   <= dly_nx;
                  armed_q <= 1'b0;
                  seen_q  <= '0;
                  cnt_q   <= '0;
               end else if (expire) begin
                  armed_q <= 1'b0;
                  seen_q  <= '0;
                  cnt_q   <= '0;
               end else if (started) begin
                  armed_q <= 1'b1;
                  cnt_q   <= cnt_nx;
                  seen_q  <= seen_nx;
                  off_q   <= off_nx;
               end
            end
            default: begin
               if (partial) begin
                  st_q   <= ST_HUNT;
                  dly_q  <= '0;
                  lost_q <= 1'b1;
               end
            end
         endcase
      end
   end

   assign tap_sel = dly_q;
   assign locked  = (st_q == ST_LOCK);
   assign lost    = lost_q;

endmodule

// File: rtl/mlane_deskew.sv
module mlane_deskew
   import deskew_pkg::*;
#(
   parameter int unsigned LANES  = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned WIN    = 8,
   parameter logic [DATA_W-1:0] MARK_CHAR = 8'h7C,
   localparam int unsigned TAP_W = $clog2(DEPTH),
   localparam int unsigned LW    = $clog2(LANES)
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [1:0]                grp_mode,
   input  logic [LANES*DATA_W-1:0]   rx_data,
   input  logic [LANES-1:0]          rx_ctrl,
   input  logic [LANES-1:0]          rx_valid,
   output logic [LANES*DATA_W-1:0]   dsk_data,
   output logic [LANES-1:0]          dsk_ctrl,
   output logic [LANES-1:0]          dsk_valid,
   output logic [LANES-1:0]          lane_locked,
   output logic [LANES-1:0]          lane_lost
);

   // Elaboration-time parameter checks
   if (!(LANES == 2 || LANES == 4 || LANES == 8)) begin : g_bad_lanes
      $error("LANES must be 2, 4 or 8");
   end
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (WIN < 1 || WIN >= DEPTH) begin : g_bad_win
      $error("WIN must be at least 1 and below DEPTH");
   end

   grp_mode_e                           mode_e;
   logic [1:0]                          mode_q;
   logic                                mode_chg;
   logic [LW-1:0]                       low_bits;
   logic [LANES-1:0]                    trk_active;
   logic [LANES-1:0][LANES-1:0]         member;
   logic [LANES-1:0][LW-1:0]            leader;
   logic [LANES-1:0]                    in_mark, tap_mark;
   logic [LANES-1:0][LANES-1:0][TAP_W-1:0] trk_tap;
   logic [LANES-1:0]                    trk_locked, trk_lost;
   logic [LANES-1:0][TAP_W-1:0]         lane_tap;

   assign mode_e = grp_mode_e'(grp_mode);

   always_ff @(posedge clk) mode_q <= grp_mode;
   assign mode_chg = (grp_mode != mode_q);

   assign low_bits = LW'(grp_low_bits(mode_e));

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         trk_active[i] = (mode_e != GRP_NONE) && ((LW'(i) & low_bits) == '0);
         leader[i]     = LW'(i) & ~low_bits;
         for (int j = 0; j < LANES; j++) begin
            member[i][j] = trk_active[i] && ((LW'(j) & ~low_bits) == LW'(i));
         end
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign in_mark[g] = rx_valid[g] && rx_ctrl[g] &&
                          (rx_data[g*DATA_W +: DATA_W] == MARK_CHAR);

      group_tracker #(
         .LANES (LANES),
         .WIN   (WIN),
         .TAP_W (TAP_W)
      ) u_trk (
         .clk      (clk),
         .rst      (rst),
         .clear    (mode_chg || !trk_active[g]),
         .member   (member[g]),
         .in_mark  (in_mark),
         .tap_mark (tap_mark),
         .tap_sel  (trk_tap[g]),
         .locked   (trk_locked[g]),
         .lost     (trk_lost[g])
      );

      assign lane_tap[g]    = trk_tap[leader[g]][g];
      assign lane_locked[g] = trk_locked[leader[g]];
      assign lane_lost[g]   = trk_lost[leader[g]];

      lane_delay_line #(
         .DATA_W    (DATA_W),
         .DEPTH     (DEPTH),
         .MARK_CHAR (MARK_CHAR)
      ) u_line (
         .clk       (clk),
         .rst       (rst),
         .in_valid  (rx_valid[g]),
         .in_ctrl   (rx_ctrl[g]),
         .in_data   (rx_data[g*DATA_W +: DATA_W]),
         .tap       (lane_tap[g]),
         .tap_mark  (tap_mark[g]),
         .out_valid (dsk_valid[g]),
         .out_ctrl  (dsk_ctrl[g]),
         .out_data  (dsk_data[g*DATA_W +: DATA_W])
      );
   end

endmodule

// File: rtl/deskew_checker.sv
module deskew_checker #(
   parameter int unsigned LANES  = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned WIN    = 8,
   parameter int unsigned TAP_W  = 4,
   parameter logic [DATA_W-1:0] MARK_CHAR = 8'h7C
) (
   input logic                        clk,
   input logic                        rst,
   input logic [1:0]                  grp_mode,
   input logic [LANES*DATA_W-1:0]     rx_data,
   input logic [LANES-1:0]            rx_ctrl,
   input logic [LANES-1:0]            rx_valid,
   input logic [LANES*DATA_W-1:0]     dsk_data,
   input logic [LANES-1:0]            dsk_ctrl,
   input logic [LANES-1:0]            dsk_valid,
   input logic [LANES-1:0]            lane_locked,
   input logic [LANES-1:0]            lane_lost,
   input logic [LANES-1:0][TAP_W-1:0] lane_tap
);

   logic [LANES-1:0] out_mark;

   always_comb begin
      for (int j = 0; j < LANES; j++) begin
         out_mark[j] = dsk_valid[j] && dsk_ctrl[j] &&
                       (dsk_data[j*DATA_W +: DATA_W] == MARK_CHAR);
      end
   end

   // R9: reset clears flags and outputs
   assert_reset_clears_R9: assert property (@(posedge clk)
      rst |=> (lane_locked == '0 && lane_lost == '0 && dsk_valid == '0));

   // R7: no lock in mode 00
   assert_none_unlocked_R7: assert property (@(posedge clk) disable iff (rst)
      grp_mode == 2'b00 |=> lane_locked == '0);

   // R7: base latency in mode 00
   assert_base_latency_R7: assert property (@(posedge clk) disable iff (rst)
      (grp_mode == 2'b00 && $past(grp_mode) == 2'b00 && $past(grp_mode, 2) == 2'b00 &&
       !$past(rst) && !$past(rst, 2))
      |-> ({dsk_valid, dsk_ctrl, dsk_data} == $past({rx_valid, rx_ctrl, rx_data}, 2)));

   // R8: mode change clears lock
   assert_mode_change_unlocks_R8: assert property (@(posedge clk) disable iff (rst)
      (grp_mode != $past(grp_mode)) |=> lane_locked == '0);

   // R3: a steadily locked eight-lane group emits whole marker columns
   assert_full_column_R3: assert property (@(posedge clk) disable iff (rst)
      (grp_mode == 2'b11 && (&lane_locked) && $past(&lane_locked) && lane_lost == '0)
      |-> (out_mark == '0 || (&out_mark)));

   for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
      // R10: tap bounded by the search window
      assert_tap_bound_R10: assert property (@(posedge clk) disable iff (rst)
         lane_tap[g] <= TAP_W'(WIN));
      // R6: loss drops lock in the same cycle
      assert_lost_unlocks_R6: assert property (@(posedge clk) disable iff (rst)
         lane_lost[g] |-> !lane_locked[g]);
      // R6: loss is a single-cycle pulse
      assert_lost_pulse_R6: assert property (@(posedge clk) disable iff (rst)
         lane_lost[g] |=> !lane_lost[g]);
   end

endmodule

bind mlane_deskew deskew_checker #(
   .LANES     (LANES),
   .DATA_W    (DATA_W),
   .WIN       (WIN),
   .TAP_W     (TAP_W),
   .MARK_CHAR (MARK_CHAR)
) u_deskew_chk (
   .clk         (clk),
   .rst         (rst),
   .grp_mode    (grp_mode),
   .rx_data     (rx_data),
   .rx_ctrl     (rx_ctrl),
   .rx_valid    (rx_valid),
   .dsk_data    (dsk_data),
   .dsk_ctrl    (dsk_ctrl),
   .dsk_valid   (dsk_valid),
   .lane_locked (lane_locked),
   .lane_lost   (lane_lost),
   .lane_tap    (lane_tap)
);

// File: tb/mlane_deskew_test.sv
`timescale 1ns/1ps
module mlane_deskew_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  grp_mode = 2'b00;
   logic [63:0] rx_data  = '0;
   logic [7:0]  rx_ctrl  = '0;
   logic [7:0]  rx_valid = '0;
   logic [63:0] dsk_data;
   logic [7:0]  dsk_ctrl, dsk_valid, lane_locked, lane_lost;

   int vectors = 0;
   int miscompares = 0;
   int t = 200;
   int skew[8];
   int exp_tap[8];
   bit vtog = 0;

   always #10 clk = ~clk;

   mlane_deskew uut (
      .clk(clk), .rst(rst), .grp_mode(grp_mode),
      .rx_data(rx_data), .rx_ctrl(rx_ctrl), .rx_valid(rx_valid),
      .dsk_data(dsk_data), .dsk_ctrl(dsk_ctrl), .dsk_valid(dsk_valid),
      .lane_locked(lane_locked), .lane_lost(lane_lost)
   );

   // Lane source pattern: marker every 20 symbols, decoys at phases 5 and 10 (R1)
   function automatic logic sym_ctrl(int j, int v);
      int ph = v % 20;
      if (ph == 0 || ph == 3) return 1'b1;
      if (ph == 5 && j == 2) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [7:0] sym_data(int j, int v);
      int ph = v % 20;
      if (ph == 0) return 8'h7C;
      if (ph == 3) return 8'hBC;
      if ((ph == 10 && j == 1) || (ph == 5 && j == 2)) return 8'h7C;
      return 8'((v * 7 + j * 29 + 3) & 255);
   endfunction

   function automatic logic sym_valid(int j, int v);
      int ph = v % 20;
      if (ph == 0) return 1'b1;
      if (ph == 5 && j == 2) return 1'b0;
      if (vtog) return ((v + j) % 7) != 3;
      return 1'b1;
   endfunction

   task automatic drive_inputs();
      for (int j = 0; j < 8; j++) begin
         int v = t - skew[j];
         rx_data[j*8 +: 8] = sym_data(j, v);
         rx_ctrl[j]        = sym_ctrl(j, v);
         rx_valid[j]       = sym_valid(j, v);
      end
   endtask

   task automatic check(bit ok, string req, string what, int act, int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic settle(int n);
      repeat (n) begin
         @(negedge clk);
         t++;
         drive_inputs();
      end
   endtask

   // Compare every lane against its source delayed by 1 + exp_tap cycles
   task automatic compare_lanes(string req);
      for (int j = 0; j < 8; j++) begin
         int v = t - 1 - exp_tap[j] - skew[j];
         logic [9:0] act = {dsk_valid[j], dsk_ctrl[j], dsk_data[j*8 +: 8]};
         logic [9:0] exp = {sym_valid(j, v), sym_ctrl(j, v), sym_data(j, v)};
         check(act == exp, req, $sformatf("lane %0d data", j), int'(act), int'(exp));
      end
   endtask

   task automatic verify(int n, string req, logic [7:0] want_lock);
      repeat (n) begin
         @(negedge clk);
         compare_lanes(req);
         check(lane_locked == want_lock, req, "lock flags", int'(lane_locked), int'(want_lock));
         check(lane_lost == 8'h00, req, "loss flags", int'(lane_lost), 0);
         t++;
         drive_inputs();
      end
   endtask

   task automatic set_skews(int s0, int s1, int s2, int s3, int s4, int s5, int s6, int s7);
      skew[0] = s0; skew[1] = s1; skew[2] = s2; skew[3] = s3;
      skew[4] = s4; skew[5] = s5; skew[6] = s6; skew[7] = s7;
   endtask

   // Expected taps: group maximum skew minus own skew, group size from mode (R2, R3)
   task automatic taps_for_group(int size, logic [7:0] lock_mask);
      for (int j = 0; j < 8; j++) begin
         int base = (j / size) * size;
         int mx = 0;
         for (int k = base; k < base + size; k++) if (skew[k] > mx) mx = skew[k];
         exp_tap[j] = lock_mask[j] ? (mx - skew[j]) : 0;
      end
   endtask

   task automatic test_reset();
      rst = 1'b1;
      grp_mode = 2'b00;
      set_skews(0, 1, 2, 3, 4, 5, 6, 7);
      drive_inputs();
      repeat (3) @(negedge clk);
      check(dsk_valid == 8'h00 && dsk_ctrl == 8'h00, "R9", "valid/ctrl after reset", int'({dsk_valid, dsk_ctrl}), 0);
      check(dsk_data == 64'h0, "R9", "data after reset", int'(dsk_data[31:0]), 0);
      check(lane_locked == 8'h00 && lane_lost == 8'h00, "R9", "flags after reset", int'({lane_locked, lane_lost}), 0);
      rst = 1'b0;
      settle(2);
   endtask

   task automatic test_passthrough();
      vtog = 1;
      grp_mode = 2'b00;
      for (int j = 0; j < 8; j++) exp_tap[j] = 0;
      settle(3);
      verify(60, "R7", 8'h00);
      vtog = 0;
   endtask

   task automatic test_quad();
      grp_mode = 2'b01;
      set_skews(2, 0, 7, 5, 1, 4, 1, 3);
      settle(100);
      taps_for_group(4, 8'hFF);
      verify(50, "R3 quad R1 R2", 8'hFF);
   endtask

   task automatic test_eight();
      grp_mode = 2'b11;
      set_skews(0, 8, 3, 5, 1, 7, 2, 6);
      settle(100);
      taps_for_group(8, 8'hFF);
      verify(50, "R3 eight-lane span R10", 8'hFF);
   endtask

   task automatic test_twin_window();
      grp_mode = 2'b10;
      set_skews(0, 9, 3, 1, 5, 5, 8, 0);
      settle(100);
      taps_for_group(2, 8'hFC);
      verify(50, "R4 R5 twin", 8'hFC);
   endtask

   task automatic test_loss();
      bit seen_lost = 0;
      grp_mode = 2'b01;
      set_skews(0, 3, 5, 8, 2, 2, 6, 4);
      settle(100);
      taps_for_group(4, 8'hFF);
      verify(30, "R3 before loss", 8'hFF);
      skew[2] = 6;
      repeat (60) begin
         @(negedge clk);
         if (lane_lost[0]) begin
            seen_lost = 1;
            check(lane_lost[3:0] == 4'hF, "R6", "loss on all quad lanes", int'(lane_lost[3:0]), 15);
            check(lane_locked[3:0] == 4'h0, "R6", "lock dropped with loss", int'(lane_locked[3:0]), 0);
         end
         check(lane_lost[7:4] == 4'h0 && lane_locked[7:4] == 4'hF, "R5", "other quad undisturbed",
               int'({lane_lost[7:4], lane_locked[7:4]}), 15);
         t++;
         drive_inputs();
      end
      check(seen_lost, "R6", "loss pulse observed", int'(seen_lost), 1);
      settle(60);
      taps_for_group(4, 8'hFF);
      verify(40, "R6 relock", 8'hFF);
   endtask

   task automatic test_mode_change();
      @(negedge clk);
      grp_mode = 2'b10;
      t++;
      drive_inputs();
      @(negedge clk);
      check(lane_locked == 8'h00, "R8", "lock cleared on mode change", int'(lane_locked), 0);
      t++;
      drive_inputs();
      settle(100);
      taps_for_group(2, 8'hFF);
      verify(40, "R8 relock as pairs R2", 8'hFF);
   endtask

   initial begin
      #4_000_000;
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      test_reset();
      test_passthrough();
      test_quad();
      test_eight();
      test_twin_window();
      test_loss();
      test_mode_change();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule